// File: doc/BRIEF.md
# Receive Clock Recovery Loop with Saturation Recovery

The block recovers a receive clock from a stream of timing events. Each event carries the phase at which it arrived. The phase detector compares that phase against a programmable window offset and adds the signed difference into an 8-bit error register. The error steers a 16-bit phase accumulator, the numerically controlled oscillator (NCO). On every clock the accumulator advances by a nominal increment plus the detector error scaled by a left shift. The accumulator's top bit, optionally inverted, is the recovered clock. The accumulator value is brought out so that software can watch the loop track.

If an event would drive the detector error past its positive or negative limit, the loop has lost track. The block then raises a sticky error flag and re-initializes the detector error according to a 2-bit recovery mode. With fast acquisition enabled, the accumulator keeps running through the error, which preserves the residual phase it already holds. With fast acquisition disabled, the accumulator reloads its programmed seed. A dedicated loop reset also reloads the seed and clears the detector. The interrupt request follows the sticky flag only while the interrupt enable is set.

Top module: `dpll_recover`

## Requirements
- R1: After reset, resid is 0, err_sticky is 0, irq is 0, and rclk equals clk_inv.
- R2: On every clock without a loop reset or a seed reload, resid advances by NOM + (detector error × 2^SCALE), modulo 2^16. NOM defaults to 0x0800 and SCALE defaults to 2. The detector error is the value held before that edge.
- R3: On a clock with ev_stb high, the detector error becomes error + d. Here d is (ev_phase − win_ofs) mod 256, read as a signed 8-bit number. This applies when the sum lies in −128..127. A sum outside that range is a saturation error.
- R4: On a saturation error with init_mode = 00, the detector error loads init_val, read as a signed 8-bit number.
- R5: On a saturation error with init_mode = 01, the detector error jumps to the opposite limit: −128 after an overflow and 127 after an underflow.
- R6: On a saturation error with init_mode = 11, the detector error becomes 0.
- R7: With init_mode = 10, an out-of-range sum clamps the detector error to the limit it crossed. No error is flagged and irq does not rise.
- R8: On a saturation error, resid advances normally when fast_acq = 1. When fast_acq = 0, resid loads seed on that edge.
- R9: While dpll_rst is high, each clock loads resid with seed and clears the detector error to 0. Events are ignored during that clock.
- R10: A saturation error sets err_sticky on the same edge, whatever the value of irq_en. A high err_clr clears err_sticky, but an error on the same edge takes priority.
- R11: irq is high exactly when err_sticky and irq_en are both 1.
- R12: rclk equals resid bit 15 XOR clk_inv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_stb | input | 1 | Timing event present this cycle |
| ev_phase | input | 8 | Phase at which the event arrived |
| win_ofs | input | 8 | Phase window offset that events are compared against |
| init_mode | input | 2 | Recovery mode: 00 load init_val, 01 opposite limit, 10 detector off (clamp), 11 zero |
| init_val | input | 8 | Signed value loaded into the detector in mode 00 |
| fast_acq | input | 1 | 1 keeps the accumulator running through an error |
| irq_en | input | 1 | Lets the sticky error drive irq |
| clk_inv | input | 1 | Inverts the recovered clock |
| dpll_rst | input | 1 | Loop reset: reload seed, clear detector |
| seed | input | 16 | Accumulator reload value |
| err_clr | input | 1 | Write-one-to-clear strobe for err_sticky |
| rclk | output | 1 | Recovered clock |
| resid | output | 16 | Current accumulator value |
| err_sticky | output | 1 | Latched saturation error |
| irq | output | 1 | Interrupt request |

## Verification
A wrong detector error is not visible directly. It shows one clock later as a wrong resid increment, and it keeps showing on every following clock until the next reload. A wrong recovery mode or a wrong overflow decision therefore appears on resid one cycle after the event that caused it. A missed seed reload or a missed error shows up on resid, err_sticky and irq on the very next edge. Because the bench compares every output on every clock, each such fault is caught within one or two cycles of its cause.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  parameter int ERR_W = 8;
  parameter int ACC_W = 16;

  typedef enum logic [1:0] {
    INIT_LOAD   = 2'b00,
    INIT_OPPOSE = 2'b01,
    INIT_OFF    = 2'b10,
    INIT_MID    = 2'b11
  } init_mode_e;

  // signed sum of current error and event offset, one bit wider
  function automatic logic signed [ERR_W:0] pd_sum(
    input logic signed [ERR_W-1:0] err,
    input logic [ERR_W-1:0] phase,
    input logic [ERR_W-1:0] ofs);
    logic [ERR_W-1:0] d;
    d = phase - ofs;
    return $signed({err[ERR_W-1], err}) + $signed({d[ERR_W-1], d});
  endfunction

  // NCO increment: nominal plus scaled detector error
  function automatic logic [ACC_W-1:0] nco_inc(
    input logic [ACC_W-1:0] nom,
    input logic signed [ERR_W-1:0] err,
    input int unsigned sh);
    logic [ACC_W-1:0] ext;
    ext = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
    return nom + (ext << sh);
  endfunction
endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
  import dpll_pkg::*;
#(
  parameter int W = ERR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_stb,
  input  logic [W-1:0]        ev_phase,
  input  logic [W-1:0]        win_ofs,
  input  logic [1:0]          init_mode,
  input  logic [W-1:0]        init_val,
  input  logic                dpll_rst,
  output logic signed [W-1:0] err_q,
  output logic                err_evt
);
  localparam logic signed [W:0] LIM_HI = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] LIM_LO = {2'b11, {(W-1){1'b0}}};

  logic signed [W:0]   sum;
  logic                over, under, out_rng;
  logic signed [W-1:0] err_d;
  init_mode_e          mode;

  assign mode    = init_mode_e'(init_mode);
  assign sum     = pd_sum(err_q, ev_phase, win_ofs);
  assign over    = sum > LIM_HI;
  assign under   = sum < LIM_LO;
  assign out_rng = ev_stb && !dpll_rst && (over || under);
  assign err_evt = out_rng && (mode != INIT_OFF);

  always_comb begin
    err_d = err_q;
    if (dpll_rst) begin
      err_d = '0;
    end else if (ev_stb) begin
      if (!out_rng) begin
        err_d = sum[W-1:0];
      end else begin
        unique case (mode)
          INIT_LOAD:   err_d = init_val;
          INIT_OPPOSE: err_d = over ? LIM_LO[W-1:0] : LIM_HI[W-1:0];
          INIT_OFF:    err_d = over ? LIM_HI[W-1:0] : LIM_LO[W-1:0];
          INIT_MID:    err_d = '0;
          default:     err_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end
endmodule

// File: rtl/dpll_nco.sv
module dpll_nco
  import dpll_pkg::*;
#(
  parameter int              AW    = ACC_W,
  parameter int              EW    = ERR_W,
  parameter logic [AW-1:0]   NOM   = 16'h0800,
  parameter int unsigned     SCALE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [EW-1:0] err,
  input  logic                 reload,
  input  logic [AW-1:0]        seed,
  output logic [AW-1:0]        acc_q
);
  logic [AW-1:0] inc;

  assign inc = nco_inc(NOM, err, SCALE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (reload) acc_q <= seed;
    else             acc_q <= acc_q + inc;
  end
endmodule

// File: rtl/dpll_err_flag.sv
module dpll_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic err_clr,
  input  logic irq_en,
  output logic sticky,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky <= 1'b0;
    else if (err_evt) sticky <= 1'b1;
    else if (err_clr) sticky <= 1'b0;
  end

  assign irq = sticky & irq_en;
endmodule

// File: rtl/dpll_recover.sv
module dpll_recover
  import dpll_pkg::*;
#(
  parameter int              EW    = ERR_W,
  parameter int              AW    = ACC_W,
  parameter logic [AW-1:0]   NOM   = 16'h0800,
  parameter int unsigned     SCALE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_stb,
  input  logic [EW-1:0] ev_phase,
  input  logic [EW-1:0] win_ofs,
  input  logic [1:0]    init_mode,
  input  logic [EW-1:0] init_val,
  input  logic          fast_acq,
  input  logic          irq_en,
  input  logic          clk_inv,
  input  logic          dpll_rst,
  input  logic [AW-1:0] seed,
  input  logic          err_clr,
  output logic          rclk,
  output logic [AW-1:0] resid,
  output logic          err_sticky,
  output logic          irq
);
  logic signed [EW-1:0] pd_err;
  logic                 err_evt;
  logic                 nco_reload;

  dpll_phase_det #(.W(EW)) u_pd (
    .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_phase(ev_phase),
    .win_ofs(win_ofs), .init_mode(init_mode), .init_val(init_val),
    .dpll_rst(dpll_rst), .err_q(pd_err), .err_evt(err_evt)
  );

  assign nco_reload = dpll_rst || (err_evt && !fast_acq);

  dpll_nco #(.AW(AW), .EW(EW), .NOM(NOM), .SCALE(SCALE)) u_nco (
    .clk(clk), .rst_n(rst_n), .err(pd_err), .reload(nco_reload),
    .seed(seed), .acc_q(resid)
  );

  dpll_err_flag u_flag (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_clr(err_clr),
    .irq_en(irq_en), .sticky(err_sticky), .irq(irq)
  );

  assign rclk = resid[AW-1] ^ clk_inv;
endmodule

// File: rtl/dpll_recover_chk.sv
module dpll_recover_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        err_evt,
  input logic        err_clr,
  input logic        fast_acq,
  input logic        dpll_rst,
  input logic [1:0]  init_mode,
  input logic [15:0] seed,
  input logic [15:0] resid,
  input logic        err_sticky,
  input logic        irq_en,
  input logic        irq,
  input logic        clk_inv,
  input logic        rclk
);
  assert_off_mode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_mode == 2'b10) |-> !err_evt);
  assert_slow_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !fast_acq) |=> (resid == $past(seed)));
  assert_loop_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dpll_rst |=> (resid == $past(seed)));
  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_sticky);
  assert_sticky_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_evt) |=> !err_sticky);
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && err_sticky) |-> irq);
  assert_rclk_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rclk == (resid[15] ^ clk_inv));
endmodule

bind dpll_recover dpll_recover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_clr(err_clr),
  .fast_acq(fast_acq), .dpll_rst(dpll_rst), .init_mode(init_mode),
  .seed(seed), .resid(resid), .err_sticky(err_sticky), .irq_en(irq_en),
  .irq(irq), .clk_inv(clk_inv), .rclk(rclk)
);

// File: tb/dpll_recover_test.sv
module dpll_recover_test;
  localparam int CLK_PERIOD = 10;
  localparam int NOMV = 'h0800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_stb = 0, fast_acq = 1, irq_en = 0, clk_inv = 1, dpll_rst = 0, err_clr = 0;
  logic [7:0] ev_phase = 0, win_ofs = 0, init_val = 0;
  logic [1:0] init_mode = 2'b11;
  logic [15:0] seed = 16'h1234;
  logic rclk, err_sticky, irq;
  logic [15:0] resid;

  int checks = 0, errors = 0;
  int m_acc = 0, m_err = 0;
  bit m_sticky = 0;
  bit done = 0;
  string req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dpll_recover uut (
    .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_phase(ev_phase),
    .win_ofs(win_ofs), .init_mode(init_mode), .init_val(init_val),
    .fast_acq(fast_acq), .irq_en(irq_en), .clk_inv(clk_inv),
    .dpll_rst(dpll_rst), .seed(seed), .err_clr(err_clr),
    .rclk(rclk), .resid(resid), .err_sticky(err_sticky), .irq(irq)
  );

  function automatic int s8(input int v);
    int t = v & 255;
    return (t > 127) ? t - 256 : t;
  endfunction

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(req, "resid", int'(resid), m_acc);
    chk(req, "err_sticky", int'(err_sticky), int'(m_sticky));
    chk("R11", "irq", int'(irq), int'(m_sticky & irq_en));
    chk("R12", "rclk", int'(rclk), ((m_acc >> 15) & 1) ^ int'(clk_inv));
  endtask

  // behavioural model of one clock edge, then compare after it
  task automatic tick();
    int d, sum, nerr, nacc;
    bit evt = 0, nst;
    d = s8(int'(ev_phase) - int'(win_ofs));
    sum = m_err + d;
    nerr = m_err;
    if (dpll_rst) nerr = 0;
    else if (ev_stb) begin
      if (sum >= -128 && sum <= 127) nerr = sum;
      else if (init_mode == 2'b10) nerr = (sum > 127) ? 127 : -128;
      else begin
        evt = 1;
        case (init_mode)
          2'b00: nerr = s8(int'(init_val));
          2'b01: nerr = (sum > 127) ? -128 : 127;
          default: nerr = 0;
        endcase
      end
    end
    if (dpll_rst || (evt && !fast_acq)) nacc = int'(seed);
    else nacc = (m_acc + NOMV + m_err * 4) & 'hFFFF;
    nst = evt ? 1'b1 : (err_clr ? 1'b0 : m_sticky);
    @(posedge clk);
    m_acc = nacc; m_err = nerr; m_sticky = nst;
    @(negedge clk);
    compare_all();
  endtask

  task automatic event_pulse(input logic [7:0] ph);
    ev_stb = 1; ev_phase = ph;
    tick();
    ev_stb = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    req = "R1";
    chk("R1", "resid", int'(resid), 0);
    chk("R1", "err_sticky", int'(err_sticky), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "rclk", int'(rclk), 1);
    rst_n = 1;

    // R2 free running at nominal rate, R12 across a wrap
    req = "R2";
    run(40);
    clk_inv = 0;
    run(10);

    // R3 accumulate signed offsets, both directions
    req = "R3";
    win_ofs = 8'd10;
    event_pulse(8'd40);   // +30
    run(3);
    event_pulse(8'd0);    // -10
    run(3);
    event_pulse(8'd250);  // +240 wraps to -16
    run(3);

    // R4 overflow with load mode, fast acquisition keeps running (R8)
    req = "R4";
    init_mode = 2'b00; init_val = 8'hFB; fast_acq = 1; irq_en = 0;
    event_pulse(8'd110);  // +100
    event_pulse(8'd110);  // overflow
    run(3);

    // R10 clear, then clear colliding with a new error
    req = "R10";
    err_clr = 1; tick(); err_clr = 0;
    run(2);
    err_clr = 1; event_pulse(8'd137); event_pulse(8'd137); err_clr = 0;
    run(2);

    // R11 enable gate on the sticky flag
    req = "R11";
    irq_en = 1; run(2);
    irq_en = 0; run(1);
    irq_en = 1;

    // R5 underflow with opposite-limit mode, seed reload (R8)
    req = "R5";
    init_mode = 2'b01; fast_acq = 0; seed = 16'hABCD;
    err_clr = 1; tick(); err_clr = 0;
    event_pulse(8'd0);    // -10 steps toward underflow
    for (int i = 0; i < 14; i++) event_pulse(8'd0);
    run(3);
    req = "R8";
    init_mode = 2'b01;
    event_pulse(8'd139);  // +129 wraps negative
    event_pulse(8'd200);
    run(3);

    // R6 center mode
    req = "R6";
    init_mode = 2'b11; fast_acq = 1;
    event_pulse(8'd110); event_pulse(8'd110); event_pulse(8'd110);
    run(3);

    // R7 detector off: clamp without flag
    req = "R7";
    err_clr = 1; tick(); err_clr = 0;
    init_mode = 2'b10;
    for (int i = 0; i < 4; i++) event_pulse(8'd110);
    run(2);
    for (int i = 0; i < 4; i++) event_pulse(8'd200);
    run(2);

    // R9 loop reset overrides a would-be error
    req = "R9";
    init_mode = 2'b00; seed = 16'h7F00;
    dpll_rst = 1; event_pulse(8'd110); event_pulse(8'd110); dpll_rst = 0;
    run(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule